// File: doc/BRIEF.md
# Analog-Shared GPIO Port Controller

This block controls a 16-pin general-purpose I/O port whose pins are also wanted by an analog converter and by a keyboard wake-up function. Those two users are represented only by per-pin claim inputs. A fixed priority gives each pin to exactly one owner. The analog claim wins over the wake-up claim, and GPIO gets the pin only when neither claims it. The block drives an output value and an output enable for every pin. Only a GPIO-owned pin whose direction bit is set can drive.

Software reaches three 16-bit registers: the stored data, the direction and a per-pin digital-input enable. It does so through a byte-wide synchronous bus, one 8-bit half at a time. Reads of the data register are direction-aware:
- An output pin returns the stored bit.
- An input pin with its digital buffer enabled returns the synchronized pin level.
- An input pin with its buffer disabled returns a constant 1.

After reset every pin behaves as a high-impedance analog input.

Top module: `gpio_ashare_port`

## Requirements
- R1: Per pin, exactly one of `grant_ana`, `grant_wake`, `grant_gpio` is 1. `grant_ana` follows `ana_claim`. `grant_wake` is set only where `wake_claim` is 1 and `ana_claim` is 0. `grant_gpio` is set only where neither claim is 1.
- R2: `pin_oe` is 1 for a pin exactly when `grant_gpio` and that pin's direction bit are both 1. `pin_out` carries the stored data bit where `pin_oe` is 1 and is 0 elsewhere.
- R3: A write to a data half stores the byte whatever the direction bits hold. The stored value becomes visible on read and on `pin_out` once the direction bit is later set to 1.
- R4: On a data read, a bit whose direction bit is 1 returns the stored data bit, not the pin level.
- R5: On a data read, a bit whose direction bit is 0 and whose input enable is 0 returns 1.
- R6: On a data read, a bit whose direction bit is 0 and whose input enable is 1 returns `pin_in` through a two-flop synchronizer. A pin change made before clock edge k is first visible after edge k+1.
- R7: Input-enable bits have no effect on pins whose direction bit is 1: `pin_oe`, `pin_out` and the read value of those bits stay unchanged.
- R8: After reset, data, direction and input-enable registers are all 0. `pin_oe` and `pin_out` are 0, and both data halves read 0xFF.
- R9: `bus_addr[2:1]` selects the register: 0 is data, 1 is direction, 2 is input enable. Direction and input enable read back their stored bytes. Code 3 reads 0x00 and ignores writes.
- R10: `bus_addr[0]` selects the half: 0 is bits 7..0 and 1 is bits 15..8. A write changes only the selected half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 3 | Register select (bits 2:1) and half select (bit 0) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Combinational read byte for `bus_addr` |
| pin_in | input | 16 | Pin levels as seen at the pads |
| ana_claim | input | 16 | Per-pin request from the analog converter |
| wake_claim | input | 16 | Per-pin request from the wake-up function |
| grant_ana | output | 16 | Pin owned by the analog converter |
| grant_wake | output | 16 | Pin owned by the wake-up function |
| grant_gpio | output | 16 | Pin owned by plain GPIO |
| pin_out | output | 16 | Output value per pin |
| pin_oe | output | 16 | Output driver enable per pin |

## Verification
The assertions assume that the claim inputs and the bus signals settle between clock edges. They also assume that a written byte is exactly what the bus presents at the sampling edge. The bench changes every input on the falling edge, so each write and each claim pattern is stable around the rising edge that samples it. The checker compares read data bit by bit against the direction and enable state held in the block. The synchronizer's two-cycle delay is therefore checked only from the bench, with pin changes placed at known edges.

// File: rtl/gpio_ashare_port.sv
module gpio_ashare_port #(
  parameter int PINS = 16,
  localparam int HALVES = PINS / 8,
  localparam int HW = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int AW = HW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] ana_claim,
  input  logic [PINS-1:0] wake_claim,
  output logic [PINS-1:0] grant_ana,
  output logic [PINS-1:0] grant_wake,
  output logic [PINS-1:0] grant_gpio,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_DIR  = 2'd1;
  localparam logic [1:0] SEL_IEN  = 2'd2;

  logic [PINS-1:0] data_q, dir_q, ien_q;
  logic [PINS-1:0] sync1_q, sync2_q;
  logic [PINS-1:0] view;

  wire [1:0]    rsel = bus_addr[AW-1 -: 2];
  wire [HW-1:0] hsel = bus_addr[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
    end else if (bus_we) begin
      for (int h = 0; h < HALVES; h++) begin
        if (hsel == HW'(h)) begin
          case (rsel)
            SEL_DATA: data_q[h*8 +: 8] <= bus_wdata;
            SEL_DIR:  dir_q[h*8 +: 8]  <= bus_wdata;
            SEL_IEN:  ien_q[h*8 +: 8]  <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign grant_ana  = ana_claim;
  assign grant_wake = wake_claim & ~ana_claim;
  assign grant_gpio = ~(ana_claim | wake_claim);

  assign pin_oe  = grant_gpio & dir_q;
  assign pin_out = data_q & pin_oe;

  assign view = (dir_q & data_q) | (~dir_q & ~ien_q) | (~dir_q & ien_q & sync2_q);

  always_comb begin
    bus_rdata = 8'h00;
    for (int h = 0; h < HALVES; h++) begin
      if (hsel == HW'(h)) begin
        case (rsel)
          SEL_DATA: bus_rdata = view[h*8 +: 8];
          SEL_DIR:  bus_rdata = dir_q[h*8 +: 8];
          SEL_IEN:  bus_rdata = ien_q[h*8 +: 8];
          default:  bus_rdata = 8'h00;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_ashare_port_chk.sv
module gpio_ashare_port_chk #(
  parameter int PINS = 16,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [7:0]      bus_wdata,
  input logic [7:0]      bus_rdata,
  input logic [PINS-1:0] grant_ana,
  input logic [PINS-1:0] grant_wake,
  input logic [PINS-1:0] grant_gpio,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] data_q,
  input logic [PINS-1:0] dir_q,
  input logic [PINS-1:0] ien_q
);

  wire data_lo = (bus_addr == AW'(0));
  wire [7:0] dlo = dir_q[7:0];
  wire [7:0] ilo = ien_q[7:0];

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_ana & grant_wake) == '0) && ((grant_gpio & (grant_ana | grant_wake)) == '0)
    && ((grant_ana | grant_wake | grant_gpio) == '1));

  assert_oe_needs_gpio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~grant_gpio) == '0) && ((pin_out & ~pin_oe) == '0));

  assert_dir_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(2)) |=> (pin_oe[7:0] == ($past(bus_wdata) & grant_gpio[7:0])));

  assert_data_write_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && data_lo) |=> (data_q[7:0] == $past(bus_wdata)));

  assert_output_reads_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_lo |-> ((bus_rdata & dlo) == (data_q[7:0] & dlo)));

  assert_disabled_reads_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_lo |-> ((bus_rdata & ~dlo & ~ilo) == (~dlo & ~ilo)));

  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(dir_q) && $stable(ien_q) && $stable(data_q)));

endmodule

bind gpio_ashare_port gpio_ashare_port_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grant_ana(grant_ana),
  .grant_wake(grant_wake), .grant_gpio(grant_gpio), .pin_out(pin_out),
  .pin_oe(pin_oe), .data_q(data_q), .dir_q(dir_q), .ien_q(ien_q)
);

// File: tb/gpio_ashare_port_tb.sv
module gpio_ashare_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in = '0, ana_claim = '0, wake_claim = '0;
  logic [15:0] grant_ana, grant_wake, grant_gpio, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ashare_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .ana_claim(ana_claim), .wake_claim(wake_claim), .grant_ana(grant_ana),
    .grant_wake(grant_wake), .grant_gpio(grant_gpio), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  // {req[3:0], waddr[2:0], wdata[7:0], pins[15:0], raddr[2:0], expect[7:0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {4'd5,  3'd2, 8'h00, 16'h00A5, 3'd0, 8'hFF},  // R5 dir 0, enable 0
    {4'd6,  3'd4, 8'hFF, 16'h00A5, 3'd0, 8'hA5},  // R6 enable on -> pins
    {4'd3,  3'd0, 8'h3C, 16'h00A5, 3'd0, 8'hA5},  // R3 stored, not shown
    {4'd4,  3'd2, 8'hF0, 16'h0000, 3'd0, 8'h30},  // R4 upper nibble from reg
    {4'd7,  3'd4, 8'h0F, 16'h00FF, 3'd0, 8'h3F},  // R7 enable only on inputs
    {4'd5,  3'd4, 8'h00, 16'h0000, 3'd0, 8'h3F},  // R5 lower reads ones
    {4'd9,  3'd3, 8'hFF, 16'h0000, 3'd3, 8'hFF},  // R9 dir readback
    {4'd10, 3'd1, 8'h81, 16'h0000, 3'd1, 8'h81},  // R10 upper half data
    {4'd9,  3'd6, 8'h55, 16'h0000, 3'd6, 8'h00},  // R9 unused code
    {4'd9,  3'd5, 8'h12, 16'h0000, 3'd5, 8'h12},  // R9 enable readback
    {4'd10, 3'd0, 8'hC3, 16'h0000, 3'd1, 8'h81}   // R10 upper untouched
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic reset_checks();
    logic [7:0] r;
    rd(3'd0, r); check("R8 data lo", {8'h0, r}, 16'h00FF);
    rd(3'd1, r); check("R8 data hi", {8'h0, r}, 16'h00FF);
    rd(3'd2, r); check("R8 dir lo", {8'h0, r}, 16'h0000);
    rd(3'd5, r); check("R8 ien hi", {8'h0, r}, 16'h0000);
    check("R8 oe", pin_oe, 16'h0000);
    check("R8 out", pin_out, 16'h0000);
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_checks();

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      pin_in = VEC[i][26:11];
      bus_we = 1'b1; bus_addr = VEC[i][37:35]; bus_wdata = VEC[i][34:27];
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = VEC[i][10:8];
      #1 check($sformatf("R%0d vector %0d", VEC[i][41:38], i), {8'h0, bus_rdata}, {8'h0, VEC[i][7:0]});
    end
    rd(3'd0, r); check("R3 stored byte now visible", {8'h0, r}, 16'h00CF);

    // state: data 81C3, dir FFF0, ien 1200
    check("R2 oe", pin_oe, 16'hFFF0);
    check("R2 out", pin_out, 16'h81C0);
    wr(3'd5, 8'hFF);
    check("R7 oe unchanged", pin_oe, 16'hFFF0);
    check("R7 out unchanged", pin_out, 16'h81C0);
    rd(3'd1, r); check("R7 read unchanged", {8'h0, r}, 16'h0081);

    @(negedge clk);
    ana_claim = 16'h0010; wake_claim = 16'h0030;
    #1;
    check("R1 ana", grant_ana, 16'h0010);
    check("R1 wake", grant_wake, 16'h0020);
    check("R1 gpio", grant_gpio, 16'hFFCF);
    check("R2 oe claimed", pin_oe, 16'hFFC0);
    check("R2 out claimed", pin_out, 16'h81C0);
    @(negedge clk);
    ana_claim = '0; wake_claim = '0;

    // R6 latency
    wr(3'd2, 8'h00);
    wr(3'd4, 8'hFF);
    @(negedge clk);
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    bus_addr = 3'd0;
    pin_in = 16'h005A;
    @(posedge clk);
    @(negedge clk);
    check("R6 after one edge", {8'h0, bus_rdata}, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    check("R6 after two edges", {8'h0, bus_rdata}, 16'h005A);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    pin_in = '0;
    reset_checks();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule